// File: doc/BRIEF.md
# Speculative Sparse Prefix Adder

This block adds two N-bit operands and a carry-in through a parallel-prefix carry tree with 1 + log2(N) levels. The first level merges each odd bit with the even bit just below it. The inner levels run a doubling-distance prefix network, but only on odd positions. The last level completes each even position by merging it with the odd position beneath. No prefix cell drives more than two others. Pass-through cells forward the group generate/propagate pair unchanged. Merge cells apply the usual (G,P) operator.

The parameter `DROP` removes that many of the final inner rows. Each odd-position carry then looks only at a window of W = 2^(log2(N) − DROP) bits. `DROP = 0` gives the exact adder. With `DROP > 0` the block returns a speculative sum and carry-out, plus a flag. The flag is raised whenever a window-limited carry disagrees with the true carry, so a consumer can trust any result that has no flag. The block is purely combinational.

Top module: `hca_spec_adder`

## Requirements
- R1: With DROP = 0 and N = 16, {cout, sum} equals a + b + cin for every input.
- R2: With DROP = 0 and N = 8, {cout, sum} equals a + b + cin over all 2^17 combinations of a, b and cin.
- R3: With DROP = 0, spec_err is always 0.
- R4: With DROP > 0, whenever spec_err is 0, {cout, sum} equals a + b + cin.
- R5: With DROP > 0, whenever spec_err is 1, {cout, sum} differs from a + b + cin, so the flag never raises a false alarm.
- R6: spec_err is 1 exactly when some odd bit position i ≥ W meets two conditions. First, bits i down to s = i − W + 1 of a XOR b are all 1. Second, the true carry into bit s (out of a[s−1:0] + b[s−1:0] + cin) is 1.
- R7: With DROP > 0, the low W bits of sum always equal the low W bits of a + b + cin.
- R8: With N = 16, a = 16'hFFFF, b = 16'h0001 and cin = 0, the exact adder gives sum 0 and cout 1, and a DROP = 1 adder raises spec_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum (speculative when DROP > 0) |
| cout | output | 1 | Carry out of bit N−1 (speculative when DROP > 0) |
| spec_err | output | 1 | High when the window-limited carries differ from the true ones |

## Verification
The speculative sum and its error flag are produced together from the same operands. The interesting case is an operand pair whose propagate run crosses a window edge while a real carry enters that run. The bench provokes this in two ways. It drives directed all-ones patterns, and it mixes random operands with near-complements of one another, which creates long propagate chains. For each vector, a behavioural integer model computes the true sum and the expected flag. The bench requires three things: the flag matches that model, a result without a flag equals the true sum, and a result with a flag does not.

// File: rtl/hca_pkg.sv
package hca_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix operator: upper group absorbs lower group.
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Sum bits from half sums and the carry into each position.
  function automatic logic sum_bit(logic half, logic carry_in);
    return half ^ carry_in;
  endfunction

endpackage

// File: rtl/hca_pregen.sv
module hca_pregen #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop,
  output logic [N-1:0] half
);
  assign half = a ^ b;

  // Carry-in is folded into bit 0 so that G[i:0] is the carry out of bit i.
  assign gen[0]  = (a[0] & b[0]) | (half[0] & cin);
  assign prop[0] = 1'b0;

  for (genvar i = 1; i < N; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = half[i];
  end
endmodule

// File: rtl/hca_tree.sv
module hca_tree
  import hca_pkg::*;
#(
  parameter int N    = 16,
  parameter int DROP = 0
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] grp_g,
  output logic [N-1:0] win_p
);
  localparam int LG   = $clog2(N);
  localparam int KEEP = LG - 1 - DROP;  // inner rows kept

  gp_t [N-1:0] lv [LG+1];

  for (genvar i = 0; i < N; i++) begin : g_col
    assign lv[0][i] = gp_t'{g: g_in[i], p: p_in[i]};

    // First sparse row: odd bit merges its lower neighbour.
    if (i % 2 == 1) begin : g_first
      assign lv[1][i] = gp_merge(lv[0][i], lv[0][i-1]);
    end else begin : g_first_pass
      assign lv[1][i] = lv[0][i];
    end

    // Dense rows on odd positions only; dropped rows become pass cells.
    for (genvar l = 2; l <= LG; l++) begin : g_row
      localparam int D = 1 << (l - 1);
      if ((i % 2 == 1) && (i >= D) && ((l - 1) <= KEEP)) begin : g_black
        assign lv[l][i] = gp_merge(lv[l-1][i], lv[l-1][i-D]);
      end else begin : g_white
        assign lv[l][i] = lv[l-1][i];
      end
    end

    // Last sparse row fills even positions from the odd one below.
    if ((i % 2 == 0) && (i >= 2)) begin : g_last
      gp_t fin;
      assign fin      = gp_merge(lv[LG][i], lv[LG][i-1]);
      assign grp_g[i] = fin.g;
    end else begin : g_last_pass
      assign grp_g[i] = lv[LG][i].g;
    end

    assign win_p[i] = lv[LG][i].p;
  end
endmodule

// File: rtl/hca_flag.sv
module hca_flag #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic [N-1:0] scar,
  input  logic [N-1:0] cex,
  input  logic [N-1:0] pwin,
  output logic         err
);
  logic [N-1:0] hit;
  logic [N-1:0] odd_m;
  logic [N-1:0] odd_hi_m;

  for (genvar i = 0; i < N; i++) begin : g_pos
    assign odd_m[i]    = (i % 2 == 1);
    assign odd_hi_m[i] = (i % 2 == 1) && (i >= W);
    if ((i % 2 == 1) && (i >= W)) begin : g_chk
      // Window [i : i-W+1] fully propagating with a real carry entering it.
      assign hit[i] = pwin[i] & cex[i-W];
    end else begin : g_none
      assign hit[i] = 1'b0;
    end
  end

  assign err = |hit;

  always_comb begin
    // R6: flag tracks any odd-position carry that slipped
    a_r6_flag_iff_carry_slip: assert ((|((scar ^ cex) & odd_m)) == err);
    // R6: a fully propagating window cannot also generate
    a_r6_window_exclusive: assert ((pwin & scar & odd_hi_m) == '0);
  end
endmodule

// File: rtl/hca_spec_adder.sv
module hca_spec_adder
  import hca_pkg::*;
#(
  parameter int N    = 16,
  parameter int DROP = 0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout,
  output logic         spec_err
);
  localparam int LG = $clog2(N);
  localparam int W  = 1 << (LG - DROP);

  logic [N-1:0] gen, prop, half;
  logic [N-1:0] cex, cspec, pwin;
  logic [N-1:0] unused_exact_pwin;
  logic [N-1:0] exact_sum, spec_sum;
  logic [N:0]   cin_ex, cin_sp;

  hca_pregen #(.N(N)) u_pre (
    .a(a), .b(b), .cin(cin), .gen(gen), .prop(prop), .half(half)
  );

  hca_tree #(.N(N), .DROP(0)) u_exact (
    .g_in(gen), .p_in(prop), .grp_g(cex), .win_p(unused_exact_pwin)
  );

  hca_tree #(.N(N), .DROP(DROP)) u_spec (
    .g_in(gen), .p_in(prop), .grp_g(cspec), .win_p(pwin)
  );

  hca_flag #(.N(N), .W(W)) u_flag (
    .scar(cspec), .cex(cex), .pwin(pwin), .err(spec_err)
  );

  assign cin_ex = {cex, cin};
  assign cin_sp = {cspec, cin};

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign exact_sum[i] = sum_bit(half[i], cin_ex[i]);
    assign spec_sum[i]  = sum_bit(half[i], cin_sp[i]);
  end

  assign sum  = spec_sum;
  assign cout = cspec[N-1];

  always_comb begin
    // R4: no flag means the speculative result is the true one
    if (!spec_err)
      a_r4_quiet_means_exact: assert ({cspec[N-1], spec_sum} == {cex[N-1], exact_sum});
    // R5: a flag is never a false alarm
    if (spec_err)
      a_r5_flag_means_wrong: assert ({cspec[N-1], spec_sum} != {cex[N-1], exact_sum});
    // R7: the bottom window is always exact
    a_r7_low_window_exact: assert (spec_sum[W-1:0] == exact_sum[W-1:0]);
  end
endmodule

// File: tb/sim_hca_spec_adder.sv
module sim_hca_spec_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst;
  int   n_chk  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  logic [15:0] a16, b16;
  logic        c16;
  logic [7:0]  a8, b8;
  logic        c8;

  logic [15:0] s0, s1, s3;
  logic        co0, co1, co3, e0, e1, e3;
  logic [7:0]  s2;
  logic        co2, e2;

  hca_spec_adder #(.N(16), .DROP(0)) u0 (.a(a16), .b(b16), .cin(c16), .sum(s0), .cout(co0), .spec_err(e0));
  hca_spec_adder #(.N(16), .DROP(1)) u1 (.a(a16), .b(b16), .cin(c16), .sum(s1), .cout(co1), .spec_err(e1));
  hca_spec_adder #(.N(8),  .DROP(0)) u2 (.a(a8),  .b(b8),  .cin(c8),  .sum(s2), .cout(co2), .spec_err(e2));
  hca_spec_adder #(.N(16), .DROP(2)) u3 (.a(a16), .b(b16), .cin(c16), .sum(s3), .cout(co3), .spec_err(e3));

  task automatic tally(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d act=%h exp=%h", tag, a16, b16, c16, act, exp);
    end
  endtask

  // Expected flag from the integer view of the operands.
  function automatic bit ref_err(int n, int w, int a, int b, bit ci);
    int pv = a ^ b;
    bit e  = 0;
    for (int i = w; i < n; i++) begin
      if (i % 2 == 1) begin
        int s    = i - w + 1;
        int mw   = (1 << w) - 1;
        int ms   = (1 << s) - 1;
        bit allp = (((pv >> s) & mw) == mw);
        bit c_s  = ((((a & ms) + (b & ms) + ci) >> s) & 1) != 0;
        e = e | (allp & c_s);
      end
    end
    return e;
  endfunction

  task automatic chk_spec(int w, logic [15:0] s, logic co, logic e, string who);
    logic [16:0] ex;
    logic [16:0] got;
    bit er;
    ex  = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
    got = {co, s};
    er  = ref_err(16, w, int'(a16), int'(b16), c16);
    tally(e == er, {"R6 ", who}, {31'd0, e}, {31'd0, er});
    if (!e) tally(got == ex, {"R4 ", who}, {15'd0, got}, {15'd0, ex});
    else    tally(got != ex, {"R5 ", who}, {15'd0, got}, {15'd0, ex});
    tally((s & 16'((1 << w) - 1)) == (ex[15:0] & 16'((1 << w) - 1)), {"R7 ", who},
          {16'd0, s}, {15'd0, ex});
  endtask

  task automatic check_all();
    logic [16:0] ex16;
    logic [8:0]  ex8;
    ex16 = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
    ex8  = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
    tally({co0, s0} == ex16, "R1 exact16", {15'd0, co0, s0}, {15'd0, ex16});
    tally(e0 == 1'b0, "R3 exact16 flag", {31'd0, e0}, 32'd0);
    tally({co2, s2} == ex8, "R2 exact8", {23'd0, co2, s2}, {23'd0, ex8});
    tally(e2 == 1'b0, "R3 exact8 flag", {31'd0, e2}, 32'd0);
    chk_spec(8, s1, co1, e1, "drop1");
    chk_spec(4, s3, co3, e3, "drop2");
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic c);
    @(posedge clk);
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [15:0] da [6];
    logic [15:0] db [6];
    logic        dc [6];
    da = '{16'hFFFF, 16'h00FF, 16'hFF00, 16'h5555, 16'h0F0F, 16'h8000};
    db = '{16'h0000, 16'h0001, 16'h00FF, 16'hAAAA, 16'hF0F0, 16'h8000};
    dc = '{1'b1,     1'b0,     1'b1,     1'b1,     1'b0,     1'b1};

    rst = 1'b1;
    a16 = '0; b16 = '0; c16 = 1'b0; a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero operands give zero outputs and no flag (R1, R3)
    tally({co0, s0} == 17'd0, "R1 reset", {15'd0, co0, s0}, 32'd0);
    tally({e0, e1, e3} == 3'b000, "R3 reset flags", {29'd0, e0, e1, e3}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < 6; k++) apply(da[k], db[k], dc[k]);

    // R8: full ripple case
    apply(16'hFFFF, 16'h0001, 1'b0);
    tally({co0, s0} == 17'h10000, "R8 exact", {15'd0, co0, s0}, 32'h10000);
    tally(e1 == 1'b1, "R8 drop1 flag", {31'd0, e1}, 32'd1);

    // R2 exhaustive at 8 bits alongside random and long-propagate 16-bit vectors
    for (int v = 0; v < (1 << 17); v++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (v % 4 == 0) rb = ~ra ^ (16'd1 << ($urandom % 16));
      @(posedge clk);
      a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
      a16 = ra; b16 = rb; c16 = 1'($urandom);
      @(negedge clk);
      check_all();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule